// File: doc/BRIEF.md
# Two-Level Priority Interrupt Acknowledge Controller

This block decides, for a small 8-bit processor core, when an interrupt is taken and what happens next. It receives three kinds of request. The first is a non-maskable request. The second is a software break, which the core raises when it executes a break instruction. The third is a set of maskable sources, each with a mask bit and a one-bit priority level. The block keeps two flags that belong in the processor status word: the interrupt-enable flag and the in-service-level flag.

At every instruction boundary the core reports, the block picks at most one request. It then drives a fixed save sequence on a simple stack port: the status word is pushed first and the program counter second. After that it hands the core the vector-table address to jump through. Two separate return strobes end a service routine. One is for maskable and non-maskable routines and one is for software-break routines. Each return pops the program counter and then the status word, and the popped status word restores both flags.

Nesting follows the in-service-level flag and the per-source priority bit. A request that is refused stays pending. It is reconsidered only at instruction boundaries, so a request held back during a routine is taken after the return and one further main-program instruction.

Top module: `intack_ctrl`

## Requirements
- R1: After reset, interrupt-enable reads 0, the in-service-level flag reads 1, and `busy`, `stk_push`, `stk_pop` and `pc_load` are all 0.
- R2: An acknowledge is decided at the clock edge that samples `insn_done` (or `brk_exec`). The next three cycles then run in order. First, `stk_push` with the pre-acknowledge status word zero-extended, with IE at bit 7, the level flag at bit 3 and the other bits 0. Second, `stk_push` with the `pc_cur` sampled at the decision. Third, `pc_load` with the vector-table address. Interrupt-enable already reads 0 in the first of these cycles.
- R3: The vector-table addresses are 0002H for the non-maskable request, 003EH for the software break, and 0004H + 2*i for maskable source i.
- R4: A software break is acknowledged whatever the enable flag and whatever is being serviced, as long as the nesting record has room.
- R5: A pending non-maskable request is acknowledged at a boundary unless a non-maskable routine is in service. It ignores the enable flag and the priority bits. A second non-maskable request during a non-maskable routine stays pending.
- R6: A maskable source is acknowledged only when interrupt-enable is 1, its mask bit (1 = blocked) is 0, and no non-maskable routine is in service.
- R7: While a maskable routine of high level (priority bit 0) is in service, the level flag reads 0. In that state, only priority-0 sources can nest and priority-1 sources stay pending. On a maskable acknowledge the level flag takes that source's priority bit. Break and non-maskable acknowledges leave the flag unchanged.
- R8: When nothing is in service, when a low-level maskable routine is in service, or when a software-break routine is in service, sources at both levels can be acknowledged, provided interrupt-enable is 1.
- R9: Selection order is as follows. The non-maskable request comes before any maskable source. Among eligible maskable sources, priority 0 comes before priority 1, and within a level the lowest index wins.
- R10: `reti_exec` ends a maskable or non-maskable routine and `retb_exec` ends a software-break routine. A strobe of the wrong kind is ignored. A return gives one cycle of `stk_pop` with `pc_load` carrying the popped word. It is followed by one cycle of `stk_pop` whose popped word restores IE from bit 7 and the level flag from bit 3.
- R11: A return strobe is never an acknowledge point. A request held back during the routine is acknowledged at the first `insn_done` after the return completes.
- R12: A `src_set` or `nmi_set` pulse latches a pending request. The request stays pending until it is acknowledged, and an acknowledge clears only the request it serves.
- R13: With the block idle, `ei_exec` sets interrupt-enable and `di_exec` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_set | input | 1 | Pulse that latches a non-maskable request |
| src_set | input | NSRC | Pulses that latch maskable requests, one per source |
| src_mask | input | NSRC | Per-source mask, 1 blocks the source |
| src_prio | input | NSRC | Per-source level, 0 high and 1 low |
| insn_done | input | 1 | Instruction boundary from the core |
| brk_exec | input | 1 | Core is executing a break instruction |
| ei_exec | input | 1 | Enable-interrupt instruction executed |
| di_exec | input | 1 | Disable-interrupt instruction executed |
| reti_exec | input | 1 | Return from maskable or non-maskable routine |
| retb_exec | input | 1 | Return from software-break routine |
| pc_cur | input | PCW | Program counter to save on acknowledge |
| stk_rdata | input | PCW | Word at the stack top, valid during a pop cycle |
| stk_push | output | 1 | Push `stk_wdata` this cycle |
| stk_pop | output | 1 | Pop the stack top this cycle |
| stk_wdata | output | PCW | Word to push |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | PCW | Vector-table address or restored program counter |
| psw_ie | output | 1 | Interrupt-enable flag |
| psw_isp | output | 1 | In-service-level flag |
| busy | output | 1 | Save or restore sequence in progress |

## Verification
The first pattern set is the full cross of five service contexts, both enable states and four request kinds. They are: nothing, high-level maskable, low-level maskable, software break and non-maskable; and non-maskable, high maskable, low maskable and break. This cross separates every nesting rule from its neighbours, for example a low source refused only under a high-level routine. The second pattern set is every combination of four pending bits, four priority bits and four mask bits. It tells the level-first, lowest-index selection and its vector apart from any other ordering. Directed sequences then cover the rest: a return of each kind and of the wrong kind, a request held back across a return, two requests latched at once and served one after the other, and the enable and disable strobes.

// File: rtl/intack_pkg.sv
// Shared types for the interrupt acknowledge controller.
// Assumes an 8-bit status word in which only the enable and level flags are owned here.
package intack_pkg;

    // What kind of routine a nesting record describes
    typedef enum logic [1:0] {
        K_MASK = 2'd0,
        K_SW   = 2'd1,
        K_NMI  = 2'd2,
        K_NONE = 2'd3
    } svc_kind_t;

    // Save / restore sequencer states
    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_PUSH_PSW = 3'd1,
        S_PUSH_PC  = 3'd2,
        S_LOAD_VEC = 3'd3,
        S_POP_PC   = 3'd4,
        S_POP_PSW  = 3'd5
    } seq_state_t;

    localparam int PSW_W       = 8;
    localparam int PSW_IE_BIT  = 7;
    localparam int PSW_ISP_BIT = 3;

    // Build the status word image from the two owned flags
    function automatic logic [PSW_W-1:0] pack_psw(input logic ie, input logic isp);
        logic [PSW_W-1:0] w;
        w = '0;
        w[PSW_IE_BIT]  = ie;
        w[PSW_ISP_BIT] = isp;
        return w;
    endfunction

endpackage

// File: rtl/intack_reqflags.sv
// Pending-request latches, one per source.
// A set pulse latches the flag; a clear removes it; a set in the same cycle wins.
module intack_reqflags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        // Hold one pending request
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_o[g] <= 1'b0;
            else if (set_i[g]) flag_o[g] <= 1'b1;
            else if (clr_i[g]) flag_o[g] <= 1'b0;
        end

        // R12
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[g] && !clr_i[g]) |=> flag_o[g]);
    end

endmodule

// File: rtl/intack_arbiter.sv
// Combinational choice of the request to acknowledge at the next boundary.
// Applies the enable, nesting-level and fixed-order rules; assumes top_kind
// describes the innermost routine in service (K_NONE when none).
module intack_arbiter
    import intack_pkg::*;
#(
    parameter int N    = 4,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_i,
    input  logic [N-1:0]    mask_i,
    input  logic [N-1:0]    prio_i,
    input  logic            nmi_pend_i,
    input  logic            ie_i,
    input  logic            isp_i,
    input  svc_kind_t       top_kind_i,
    input  logic            full_i,
    output logic            take_o,
    output logic            take_nmi_o,
    output logic [IDXW-1:0] take_idx_o,
    output logic            take_lvl_o,
    output logic [N-1:0]    take_onehot_o
);

    logic [N-1:0]    hi_vec, lo_vec;
    logic            hi_any, lo_any, allow_mask, allow_lo, mask_ok;
    logic [IDXW-1:0] hi_idx, lo_idx;

    assign hi_vec = req_i & ~mask_i & ~prio_i;
    assign lo_vec = req_i & ~mask_i &  prio_i;

    // Lowest set index within each level
    always_comb begin
        hi_any = 1'b0;
        lo_any = 1'b0;
        hi_idx = '0;
        lo_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hi_vec[i]) begin
                hi_any = 1'b1;
                hi_idx = IDXW'(i);
            end
            if (lo_vec[i]) begin
                lo_any = 1'b1;
                lo_idx = IDXW'(i);
            end
        end
    end

    // Nesting rules and final pick
    always_comb begin
        take_nmi_o = nmi_pend_i && (top_kind_i != K_NMI) && !full_i;
        allow_mask = ie_i && (top_kind_i != K_NMI) && !full_i;
        allow_lo   = !((top_kind_i == K_MASK) && !isp_i);
        mask_ok    = allow_mask && (hi_any || (allow_lo && lo_any));
        take_o     = take_nmi_o || mask_ok;
        take_idx_o = hi_any ? hi_idx : lo_idx;
        take_lvl_o = !hi_any;
        for (int i = 0; i < N; i++)
            take_onehot_o[i] = mask_ok && !take_nmi_o && (take_idx_o == IDXW'(i));
    end

    // R6
    mask_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !take_nmi_o) |-> (ie_i && top_kind_i != K_NMI));

    // R7
    level_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !take_nmi_o && top_kind_i == K_MASK && !isp_i) |-> !take_lvl_o);

    // R9
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend_i && top_kind_i != K_NMI && !full_i) |-> (take_o && take_onehot_o == '0));

endmodule

// File: rtl/intack_kindstack.sv
// Small record of which kind of routine each nesting level is serving.
// Assumes the caller never pushes when full nor pops when empty.
module intack_kindstack
    import intack_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  svc_kind_t kind_i,
    input  logic      pop_i,
    output svc_kind_t top_o,
    output logic      full_o
);

    svc_kind_t       mem [DEPTH];
    logic [CW-1:0]   cnt;

    assign full_o = (cnt == CW'(DEPTH));
    assign top_o  = (cnt == '0) ? K_NONE : mem[cnt[AW-1:0] - AW'(1)];

    // Depth counter
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (push_i) cnt <= cnt + CW'(1);
        else if (pop_i)  cnt <= cnt - CW'(1);
    end

    // Record storage, written on push only
    always_ff @(posedge clk) begin
        if (push_i) mem[cnt[AW-1:0]] <= kind_i;
    end

    // R2
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R10
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (cnt != '0));

endmodule

// File: rtl/intack_ctrl.sv
// Interrupt acknowledge controller: latches requests, decides at instruction
// boundaries, sequences the status-word and PC save, supplies the vector-table
// address, and restores both flags on return. Assumes the core raises at most
// one of insn_done / brk_exec / reti_exec / retb_exec per cycle and waits while busy.
module intack_ctrl
    import intack_pkg::*;
#(
    parameter int             NSRC     = 4,
    parameter int             PCW      = 16,
    parameter int             DEPTH    = 8,
    parameter logic [PCW-1:0] VEC_NMI  = 16'h0002,
    parameter logic [PCW-1:0] VEC_BRK  = 16'h003E,
    parameter logic [PCW-1:0] VEC_BASE = 16'h0004
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nmi_set,
    input  logic [NSRC-1:0] src_set,
    input  logic [NSRC-1:0] src_mask,
    input  logic [NSRC-1:0] src_prio,
    input  logic            insn_done,
    input  logic            brk_exec,
    input  logic            ei_exec,
    input  logic            di_exec,
    input  logic            reti_exec,
    input  logic            retb_exec,
    input  logic [PCW-1:0]  pc_cur,
    input  logic [PCW-1:0]  stk_rdata,
    output logic            stk_push,
    output logic            stk_pop,
    output logic [PCW-1:0]  stk_wdata,
    output logic            pc_load,
    output logic [PCW-1:0]  pc_next,
    output logic            psw_ie,
    output logic            psw_isp,
    output logic            busy
);

    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

    seq_state_t       state;
    logic             ie_q, isp_q;
    logic [PSW_W-1:0] sav_psw;
    logic [PCW-1:0]   sav_pc, vec_q;

    logic [NSRC-1:0]  src_pend, src_clr, take_onehot;
    logic             nmi_pend, nmi_clr;
    logic             take, take_nmi, take_lvl, full;
    logic [IDXW-1:0]  take_idx;
    svc_kind_t        top_kind, push_kind;
    logic             idle, brk_go, grant, ack_go, ret_go;
    logic [PCW-1:0]   src_vec;

    assign idle   = (state == S_IDLE);
    assign brk_go = idle && brk_exec && !full;
    assign grant  = idle && insn_done && take && !brk_exec && !reti_exec && !retb_exec;
    assign ack_go = brk_go || grant;
    assign ret_go = idle && !brk_exec &&
                    ((reti_exec && (top_kind == K_MASK || top_kind == K_NMI)) ||
                     (retb_exec && top_kind == K_SW));

    assign src_clr   = grant ? take_onehot : '0;
    assign nmi_clr   = grant && take_nmi;
    assign push_kind = brk_go ? K_SW : (take_nmi ? K_NMI : K_MASK);
    assign src_vec   = VEC_BASE + {{(PCW-IDXW-1){1'b0}}, take_idx, 1'b0};

    intack_reqflags #(.N(NSRC)) u_src_flags (
        .clk(clk), .rst_n(rst_n), .set_i(src_set), .clr_i(src_clr), .flag_o(src_pend)
    );

    intack_reqflags #(.N(1)) u_nmi_flag (
        .clk(clk), .rst_n(rst_n), .set_i(nmi_set), .clr_i(nmi_clr), .flag_o(nmi_pend)
    );

    intack_arbiter #(.N(NSRC), .IDXW(IDXW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .req_i(src_pend), .mask_i(src_mask), .prio_i(src_prio),
        .nmi_pend_i(nmi_pend), .ie_i(ie_q), .isp_i(isp_q),
        .top_kind_i(top_kind), .full_i(full),
        .take_o(take), .take_nmi_o(take_nmi), .take_idx_o(take_idx),
        .take_lvl_o(take_lvl), .take_onehot_o(take_onehot)
    );

    intack_kindstack #(.DEPTH(DEPTH)) u_kinds (
        .clk(clk), .rst_n(rst_n),
        .push_i(ack_go), .kind_i(push_kind),
        .pop_i(state == S_POP_PSW),
        .top_o(top_kind), .full_o(full)
    );

    // Sequencer: idle -> save three steps, or idle -> restore two steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:     if (ack_go) state <= S_PUSH_PSW;
                            else if (ret_go) state <= S_POP_PC;
                S_PUSH_PSW: state <= S_PUSH_PC;
                S_PUSH_PC:  state <= S_LOAD_VEC;
                S_LOAD_VEC: state <= S_IDLE;
                S_POP_PC:   state <= S_POP_PSW;
                S_POP_PSW:  state <= S_IDLE;
                default:    state <= S_IDLE;
            endcase
        end
    end

    // Capture of the words to save and the vector at the decision edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sav_psw <= '0;
            sav_pc  <= '0;
            vec_q   <= '0;
        end else if (ack_go) begin
            sav_psw <= pack_psw(ie_q, isp_q);
            sav_pc  <= pc_cur;
            vec_q   <= brk_go ? VEC_BRK : (take_nmi ? VEC_NMI : src_vec);
        end
    end

    // Status-word flags: cleared on acknowledge, restored on return, EI/DI when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            isp_q <= 1'b1;
        end else if (ack_go) begin
            ie_q <= 1'b0;
            if (grant && !take_nmi) isp_q <= take_lvl;
        end else if (state == S_POP_PSW) begin
            ie_q  <= stk_rdata[PSW_IE_BIT];
            isp_q <= stk_rdata[PSW_ISP_BIT];
        end else if (idle && !ret_go) begin
            if (ei_exec)      ie_q <= 1'b1;
            else if (di_exec) ie_q <= 1'b0;
        end
    end

    // Stack and program-counter drive per state
    always_comb begin
        stk_push  = (state == S_PUSH_PSW) || (state == S_PUSH_PC);
        stk_pop   = (state == S_POP_PC) || (state == S_POP_PSW);
        stk_wdata = (state == S_PUSH_PSW) ? {{(PCW-PSW_W){1'b0}}, sav_psw} :
                    (state == S_PUSH_PC)  ? sav_pc : '0;
        pc_load   = (state == S_LOAD_VEC) || (state == S_POP_PC);
        pc_next   = (state == S_LOAD_VEC) ? vec_q :
                    (state == S_POP_PC)   ? stk_rdata : '0;
    end

    assign psw_ie  = ie_q;
    assign psw_isp = isp_q;
    assign busy    = !idle;

    // R2
    ie_off_at_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_push) |-> !psw_ie);

    // R2
    push_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_push && $past(stk_push)) |=> (pc_load && !stk_push));

    // R11
    no_ack_on_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stk_pop) |-> !stk_push);

endmodule

// File: tb/intack_ctrl_test.sv
// Self-checking bench: context x enable x request sweep, full selection sweep,
// and directed return / pending / enable sequences.
module intack_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_set = 0, insn_done = 0, brk_exec = 0, ei_exec = 0, di_exec = 0;
    logic reti_exec = 0, retb_exec = 0;
    logic [N-1:0] src_set = '0, src_mask = '0, src_prio = '0;
    logic [15:0] pc_cur = 16'hA5C0;
    logic [15:0] stk_rdata, stk_wdata, pc_next;
    logic stk_push, stk_pop, pc_load, psw_ie, psw_isp, busy;

    int checks = 0;
    int fails = 0;
    logic b_ie, b_isp;

    // Behavioural stack memory standing in for the core's stack
    logic [15:0] smem [16];
    int sp = 0;
    assign stk_rdata = (sp > 0) ? smem[sp-1] : 16'h0000;
    always @(posedge clk) begin
        if (!rst_n) sp <= 0;
        else if (stk_push) begin smem[sp] <= stk_wdata; sp <= sp + 1; end
        else if (stk_pop) sp <= sp - 1;
    end

    intack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .nmi_set(nmi_set), .src_set(src_set),
        .src_mask(src_mask), .src_prio(src_prio), .insn_done(insn_done),
        .brk_exec(brk_exec), .ei_exec(ei_exec), .di_exec(di_exec),
        .reti_exec(reti_exec), .retb_exec(retb_exec), .pc_cur(pc_cur),
        .stk_rdata(stk_rdata), .stk_push(stk_push), .stk_pop(stk_pop),
        .stk_wdata(stk_wdata), .pc_load(pc_load), .pc_next(pc_next),
        .psw_ie(psw_ie), .psw_isp(psw_isp), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        b_ie = 1'b0; b_isp = 1'b1;
    endtask

    // One-cycle strobe: 0 src,1 nmi,2 ei,3 di,4 boundary,5 break,6 reti,7 retb
    task automatic pulse(input int code, input logic [N-1:0] v);
        case (code)
            0: src_set = v;
            1: nmi_set = 1'b1;
            2: ei_exec = 1'b1;
            3: di_exec = 1'b1;
            4: insn_done = 1'b1;
            5: brk_exec = 1'b1;
            6: reti_exec = 1'b1;
            default: retb_exec = 1'b1;
        endcase
        cyc();
        src_set = '0; nmi_set = 0; ei_exec = 0; di_exec = 0;
        insn_done = 0; brk_exec = 0; reti_exec = 0; retb_exec = 0;
        if (code == 2) b_ie = 1'b1;
        if (code == 3) b_ie = 1'b0;
    endtask

    // Sampled one negedge after the decision edge; new_isp < 0 leaves the level
    task automatic expect_ack(input bit exp_acc, input logic [15:0] vec,
                              input int new_isp, input string req);
        chk(stk_push == exp_acc, req, "acknowledge", stk_push, exp_acc);
        if (stk_push && exp_acc) begin
            chk(stk_wdata == {8'h00, b_ie, 3'b000, b_isp, 3'b000}, "R2", "pushed status word",
                stk_wdata, {8'h00, b_ie, 3'b000, b_isp, 3'b000});
            chk(psw_ie == 1'b0, "R2", "enable cleared", psw_ie, 0);
            cyc();
            chk(stk_push && stk_wdata == pc_cur, "R2", "pushed pc", stk_wdata, pc_cur);
            cyc();
            chk(pc_load && pc_next == vec, "R3", "vector address", pc_next, vec);
            cyc();
            b_ie = 1'b0;
            if (new_isp >= 0) b_isp = new_isp[0];
        end
    endtask

    // Return strobe; when accepted check both pops and the restored flags
    task automatic do_ret(input bit use_b, input bit exp_act, input logic [15:0] exp_pc,
                          input logic e_ie, input logic e_isp);
        pulse(use_b ? 7 : 6, '0);
        chk(stk_pop == exp_act, "R10", "return accepted", stk_pop, exp_act);
        if (exp_act) begin
            chk(pc_load && pc_next == exp_pc, "R10", "restored pc", pc_next, exp_pc);
            cyc();
            chk(stk_pop == 1'b1, "R10", "second pop", stk_pop, 1);
            cyc();
            chk(psw_ie == e_ie && psw_isp == e_isp, "R10", "restored flags",
                {psw_ie, psw_isp}, {e_ie, e_isp});
            chk(stk_push == 1'b0 && busy == 1'b0, "R11", "no acknowledge at return",
                stk_push, 0);
            b_ie = e_ie; b_isp = e_isp;
        end
    endtask

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cyc();
        do_reset();
        // R1 reset state
        chk(psw_ie == 0 && psw_isp == 1, "R1", "reset flags", {psw_ie, psw_isp}, 2'b01);
        chk(!busy && !stk_push && !stk_pop && !pc_load, "R1", "reset strobes",
            {busy, stk_push, stk_pop, pc_load}, 0);

        // Sweep: context x enable x request kind (src0,1 high; src2,3 low)
        for (int ctx = 0; ctx < 5; ctx++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int t = 0; t < 4; t++) begin
                    bit acc;
                    string rq;
                    do_reset();
                    src_prio = 4'b1100; src_mask = '0;
                    pulse(2, '0);
                    case (ctx)
                        1: begin pulse(0, 4'b0001); pulse(4, '0); expect_ack(1, 16'h0004, 0, "R7"); end
                        2: begin pulse(0, 4'b1000); pulse(4, '0); expect_ack(1, 16'h000A, 1, "R8"); end
                        3: begin pulse(5, '0); expect_ack(1, 16'h003E, -1, "R4"); end
                        4: begin pulse(1, '0); pulse(4, '0); expect_ack(1, 16'h0002, -1, "R5"); end
                        default: ;
                    endcase
                    pulse(ie ? 2 : 3, '0);
                    if (t == 3) begin
                        acc = 1; rq = "R4";
                        pulse(5, '0);
                        expect_ack(acc, 16'h003E, -1, rq);
                    end else begin
                        if (t == 0) begin
                            acc = (ctx != 4); rq = "R5";
                            pulse(1, '0);
                        end else begin
                            acc = (ctx != 4) && (ie == 1) && !(ctx == 1 && t == 2);
                            rq = (ie == 0 || ctx == 4) ? "R6" : (ctx == 1 && t == 2) ? "R7" : "R8";
                            pulse(0, (t == 1) ? 4'b0010 : 4'b0100);
                        end
                        pulse(4, '0);
                        expect_ack(acc, (t == 0) ? 16'h0002 : (t == 1) ? 16'h0006 : 16'h0008,
                                   (t == 0) ? -1 : (t == 1) ? 0 : 1, rq);
                    end
                end
            end
        end

        // Sweep: pending x priority x mask, level-first then lowest index (R9)
        for (int p = 1; p < 16; p++) begin
            for (int q = 0; q < 16; q++) begin
                for (int m = 0; m < 16; m++) begin
                    logic [N-1:0] el;
                    int w;
                    do_reset();
                    src_prio = q[N-1:0]; src_mask = m[N-1:0];
                    pc_cur = {p[3:0], q[3:0], m[3:0], 4'h1};
                    pulse(0, p[N-1:0]);
                    pulse(2, '0);
                    pulse(4, '0);
                    el = p[N-1:0] & ~m[N-1:0];
                    w = (lowest(el & ~q[N-1:0]) >= 0) ? lowest(el & ~q[N-1:0]) : lowest(el);
                    expect_ack(w >= 0, 16'h0004 + 16'(2 * ((w < 0) ? 0 : w)),
                               (w < 0) ? -1 : int'(q[(w < 0) ? 0 : w]), "R9");
                end
            end
        end
        pc_cur = 16'hA5C0;

        // Non-maskable before maskable when both pending (R9)
        do_reset(); src_prio = '0; src_mask = '0;
        pulse(0, 4'b0001); pulse(1, '0); pulse(2, '0); pulse(4, '0);
        expect_ack(1, 16'h0002, -1, "R9");

        // Held-back low request across a return (R7, R10, R11, R12)
        do_reset(); src_prio = 4'b1100; src_mask = '0;
        pulse(2, '0); pulse(0, 4'b0001); pulse(4, '0);
        expect_ack(1, 16'h0004, 0, "R7");
        pulse(2, '0); pulse(0, 4'b0100); pulse(4, '0);
        expect_ack(0, 16'h0008, -1, "R7");
        do_ret(0, 1, 16'hA5C0, 1'b1, 1'b1);
        pulse(4, '0);
        expect_ack(1, 16'h0008, 1, "R11");

        // Wrong return kind ignored, right one restores (R10)
        do_reset(); src_mask = '0;
        pulse(2, '0); pulse(5, '0);
        expect_ack(1, 16'h003E, -1, "R4");
        do_ret(0, 0, 16'h0000, 1'b0, 1'b1);
        chk(busy == 0 && psw_ie == 0, "R10", "wrong return left state", {busy, psw_ie}, 0);
        do_ret(1, 1, 16'hA5C0, 1'b1, 1'b1);

        // Two latched together, served one after the other (R12)
        do_reset(); src_prio = '0; src_mask = '0;
        pulse(0, 4'b0011); pulse(2, '0); pulse(4, '0);
        expect_ack(1, 16'h0004, 0, "R12");
        pulse(2, '0); pulse(4, '0);
        expect_ack(1, 16'h0006, 0, "R12");
        pulse(2, '0); pulse(4, '0);
        expect_ack(0, 16'h0000, -1, "R12");

        // Enable / disable strobes (R13)
        do_reset(); src_prio = '0; src_mask = '0;
        pulse(0, 4'b0001); pulse(4, '0);
        expect_ack(0, 16'h0004, -1, "R13");
        pulse(2, '0);
        chk(psw_ie == 1, "R13", "ei sets enable", psw_ie, 1);
        pulse(3, '0);
        chk(psw_ie == 0, "R13", "di clears enable", psw_ie, 0);
        pulse(2, '0); pulse(4, '0);
        expect_ack(1, 16'h0004, 0, "R13");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule